// File: doc/BRIEF.md
# Adaptive SEC-DED Memory Scrubber

This block walks a word-addressed memory whose words carry 64 data bits and 8 check bits, reading every word in turn, decoding it, and rewriting the repaired word whenever exactly one bit has flipped. Two flipped bits in one word are detected but cannot be repaired. Such a word is left untouched, its address is recorded and a sticky interrupt is raised. Both kinds of event are counted in saturating counters.

The scrubber shares the memory with functional masters through an external arbiter. It raises a request and only performs an access in a cycle where the grant is also high. The memory is synchronous: a granted read returns its word on the next cycle. Passes over the memory are separated by an idle interval. The interval starts at a configured base value. It halves, down to a configured floor, after any pass that repaired a word, and it doubles, up to the base, after a pass that repaired nothing. The scrub rate therefore rises while upsets are frequent and relaxes while the memory is clean.

Top module: `adaptive_scrubber`

## Requirements
- R1: Word layout: bits 63:0 hold data, bits 70:64 hold Hamming check bits (bit 64+k is the parity over the data bits whose codeword position has bit k set; data occupies positions 1..71 that are not powers of two, in ascending order), and bit 71 makes the parity of all 72 bits even. A word with no error is never written back and changes no counter.
- R2: A word with a single flipped bit (data, check or bit 71) is written back, corrected, to the same address it was read from, and the corrected counter increments.
- R3: A word with two flipped bits is never written. Its address appears on `err_addr`, `err_irq` goes high and stays high until reset, and the uncorrectable counter increments.
- R4: An access takes place only in a cycle where `mem_req` and `mem_gnt` are both high. A granted read delivers `mem_rdata` on the following cycle. While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R5: Each pass reads addresses 0 to DEPTH-1 in ascending order, once each, and the next pass begins again at 0.
- R6: After reset the interval equals `cfg_base_interval`. Between passes `mem_req` is low for the interval I plus 2 cycles when the last word needs no rewrite, and for exactly I cycles when the last word was rewritten.
- R7: After a pass that corrected at least one word, the interval becomes half of its previous value, but never less than `cfg_min_interval`.
- R8: After a pass that corrected no word, the interval becomes twice its previous value, but never more than `cfg_base_interval`.
- R9: Both error counters stop at their all-ones value instead of wrapping.
- R10: Synchronous active-low reset clears `mem_req`, `err_irq` and both counters.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_base_interval | input | INT_W | Longest idle interval between passes, in cycles |
| cfg_min_interval | input | INT_W | Shortest idle interval between passes, in cycles |
| mem_req | output | 1 | Access request to the arbiter |
| mem_gnt | input | 1 | Grant from the arbiter |
| mem_addr | output | ADDR_W | Word address |
| mem_we | output | 1 | Write enable (1 = write-back, 0 = read) |
| mem_wdata | output | 72 | Corrected word for write-back |
| mem_rdata | input | 72 | Word read, valid the cycle after a granted read |
| corr_count | output | CNT_W | Saturating count of corrected words |
| uncorr_count | output | CNT_W | Saturating count of uncorrectable words |
| err_addr | output | ADDR_W | Address of the latest uncorrectable word |
| err_irq | output | 1 | Sticky uncorrectable-error interrupt |

## Verification
Two functions can fall together when the final word of a pass carries a single-bit error. Its write-back then ends the pass, so the interval update and the rewrite land on the same transition. The bench places a repairable error in the last word of one pass while the grant pattern also stalls requests. It then checks that the idle gap before the next pass equals the halved interval with no extra cycles. It also checks that the scoreboard received exactly that one corrected word at the last address.

// File: rtl/scrub_pkg.sv
// Shared constants, types and code-position helpers for the scrubber.
// Assumes the 72-bit layout: data [63:0], Hamming checks [70:64], overall parity [71].
package scrub_pkg;

    localparam int DATA_W  = 64;
    localparam int CHK_W   = 7;
    localparam int WORD_W  = 72;
    localparam int POS_MAX = 71;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_SINGLE = 2'd1,
        ECC_DOUBLE = 2'd2
    } ecc_kind_e;

    // Map a Hamming codeword position (1..71) to its storage bit index.
    function automatic int pos_to_bit(input int pos);
        int pow_cnt;
        pow_cnt = 0;
        for (int k = 0; k < CHK_W; k++) begin
            if ((32'sd1 <<< k) <= pos) pow_cnt++;
        end
        if ((pos & (pos - 1)) == 0) return DATA_W + pow_cnt - 1;
        return pos - 1 - pow_cnt;
    endfunction

    // XOR of the positions of all set bits of the Hamming part of a word.
    function automatic logic [CHK_W-1:0] calc_syndrome(input logic [WORD_W-1:0] w);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p <= POS_MAX; p++) begin
            if (w[7'(pos_to_bit(p))]) s ^= CHK_W'(p);
        end
        return s;
    endfunction

endpackage

// File: rtl/scrub_secded_dec.sv
// Combinational SEC-DED classifier and single-bit corrector for one 72-bit word.
// Assumes the layout defined in scrub_pkg; a syndrome beyond position 71 is treated as uncorrectable.
module scrub_secded_dec
    import scrub_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output ecc_kind_e         kind_o,
    output logic [WORD_W-1:0] fixed_o
);

    logic [CHK_W-1:0] syn;
    logic             odd;
    logic [6:0]       flip_idx;

    // Classify the word and build its corrected form.
    always_comb begin
        syn      = calc_syndrome(word_i);
        odd      = ^word_i;
        fixed_o  = word_i;
        kind_o   = ECC_CLEAN;
        flip_idx = 7'(WORD_W - 1);
        if (odd) begin
            if (syn == '0) begin
                kind_o = ECC_SINGLE;
            end else if (int'(syn) <= POS_MAX) begin
                kind_o   = ECC_SINGLE;
                flip_idx = 7'(pos_to_bit(int'(syn)));
            end else begin
                kind_o = ECC_DOUBLE;
            end
            if (kind_o == ECC_SINGLE) fixed_o[flip_idx] = ~word_i[flip_idx];
        end else if (syn != '0) begin
            kind_o = ECC_DOUBLE;
        end
    end

endmodule

// File: rtl/scrub_sat_cnt.sv
// Saturating event counter: counts single-cycle pulses and sticks at all-ones.
// Assumes at most one event per cycle.
module scrub_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    // Count events until the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + W'(1);
    end

endmodule

// File: rtl/scrub_interval_ctl.sv
// Holds the adaptive pass interval and times the idle gap between passes.
// Assumes pass_done_i is a one-cycle pulse and idle_i is high while the walker waits.
module scrub_interval_ctl #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] cfg_base_i,
    input  logic [INT_W-1:0] cfg_min_i,
    input  logic             idle_i,
    input  logic             pass_done_i,
    input  logic             pass_corr_i,
    output logic             idle_done_o
);

    logic [INT_W-1:0] cur_q;
    logic [INT_W-1:0] wait_q;
    logic [INT_W-1:0] half_v;
    logic [INT_W:0]   dbl_v;
    logic [INT_W-1:0] next_v;

    // Pick the next interval from the outcome of the finished pass.
    always_comb begin
        half_v = cur_q >> 1;
        dbl_v  = {cur_q, 1'b0};
        if (pass_corr_i) next_v = (half_v < cfg_min_i) ? cfg_min_i : half_v;
        else             next_v = (dbl_v > {1'b0, cfg_base_i}) ? cfg_base_i : dbl_v[INT_W-1:0];
    end

    // Idle period ends once it has lasted cur_q cycles.
    assign idle_done_o = idle_i && (({1'b0, wait_q} + (INT_W+1)'(1)) >= {1'b0, cur_q});

    // Update the interval at the end of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n)           cur_q <= cfg_base_i;
        else if (pass_done_i) cur_q <= next_v;
    end

    // Count idle cycles; restart whenever the walker is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wait_q <= '0;
        else if (idle_i && !idle_done_o) wait_q <= wait_q + INT_W'(1);
        else                            wait_q <= '0;
    end

endmodule

// File: rtl/scrub_walker.sv
// Address walker and access sequencer: read, evaluate, optional write-back, advance.
// Assumes a synchronous memory returning read data one cycle after a granted read.
module scrub_walker
    import scrub_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_done_i,
    input  logic              mem_gnt_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  ecc_kind_e         kind_i,
    input  logic [WORD_W-1:0] fixed_i,
    output logic [WORD_W-1:0] held_word_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              idle_o,
    output logic              pass_done_o,
    output logic              pass_corr_o,
    output logic              corr_o,
    output logic              uncorr_o
);

    typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_EVAL, S_WR} walk_st_e;

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    walk_st_e          st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wbuf_q;
    logic              corr_seen_q;
    logic              advance;

    // Decode the state into memory controls and event pulses.
    always_comb begin
        advance     = (st_q == S_EVAL && kind_i != ECC_SINGLE) || (st_q == S_WR && mem_gnt_i);
        pass_done_o = advance && (addr_q == LAST_ADDR);
        mem_req_o   = (st_q == S_RD) || (st_q == S_WR);
        mem_we_o    = (st_q == S_WR);
        idle_o      = (st_q == S_IDLE);
        corr_o      = (st_q == S_EVAL) && (kind_i == ECC_SINGLE);
        uncorr_o    = (st_q == S_EVAL) && (kind_i == ECC_DOUBLE);
    end

    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = wbuf_q;
    assign pass_corr_o = corr_seen_q;

    // Sequence the per-word read, evaluate and write-back steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            addr_q      <= '0;
            held_word_o <= '0;
            wbuf_q      <= '0;
            corr_seen_q <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (idle_done_i) st_q <= S_RD;
                S_RD:   if (mem_gnt_i)   st_q <= S_WAIT;
                S_WAIT: begin
                    held_word_o <= mem_rdata_i;
                    st_q        <= S_EVAL;
                end
                S_EVAL: begin
                    if (kind_i == ECC_SINGLE) begin
                        wbuf_q      <= fixed_i;
                        corr_seen_q <= 1'b1;
                        st_q        <= S_WR;
                    end
                end
                S_WR: ;
                default: st_q <= S_IDLE;
            endcase
            if (advance) begin
                if (addr_q == LAST_ADDR) begin
                    addr_q      <= '0;
                    corr_seen_q <= 1'b0;
                    st_q        <= S_IDLE;
                end else begin
                    addr_q <= addr_q + ADDR_W'(1);
                    st_q   <= S_RD;
                end
            end
        end
    end

endmodule

// File: rtl/adaptive_scrubber.sv
// Top level of the adaptive SEC-DED scrubber: walker, decoder, interval control, counters.
// Assumes an external arbiter and a synchronous 72-bit memory with one-cycle read latency.
module adaptive_scrubber
    import scrub_pkg::*;
#(
    parameter  int DEPTH  = 1024,
    parameter  int INT_W  = 16,
    parameter  int CNT_W  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  cfg_base_interval,
    input  logic [INT_W-1:0]  cfg_min_interval,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  corr_count,
    output logic [CNT_W-1:0]  uncorr_count,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_irq
);

    logic [WORD_W-1:0] held_word;
    logic [WORD_W-1:0] fixed_word;
    ecc_kind_e         kind;
    logic              idle, idle_done, pass_done, pass_corr, corr_ev, uncorr_ev;

    scrub_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) walker_i (
        .clk(clk), .rst_n(rst_n), .idle_done_i(idle_done), .mem_gnt_i(mem_gnt),
        .mem_rdata_i(mem_rdata), .kind_i(kind), .fixed_i(fixed_word),
        .held_word_o(held_word), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .idle_o(idle),
        .pass_done_o(pass_done), .pass_corr_o(pass_corr),
        .corr_o(corr_ev), .uncorr_o(uncorr_ev)
    );

    scrub_secded_dec dec_i (.word_i(held_word), .kind_o(kind), .fixed_o(fixed_word));

    scrub_interval_ctl #(.INT_W(INT_W)) ival_i (
        .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base_interval), .cfg_min_i(cfg_min_interval),
        .idle_i(idle), .pass_done_i(pass_done), .pass_corr_i(pass_corr), .idle_done_o(idle_done)
    );

    scrub_sat_cnt #(.W(CNT_W)) corr_cnt_i   (.clk(clk), .rst_n(rst_n), .inc_i(corr_ev),   .cnt_o(corr_count));
    scrub_sat_cnt #(.W(CNT_W)) uncorr_cnt_i (.clk(clk), .rst_n(rst_n), .inc_i(uncorr_ev), .cnt_o(uncorr_count));

    // Latch the failing address and hold the interrupt until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_irq  <= 1'b0;
            err_addr <= '0;
        end else if (uncorr_ev) begin
            err_irq  <= 1'b1;
            err_addr <= mem_addr;
        end
    end

endmodule

// File: rtl/adaptive_scrubber_chk.sv
// Protocol and counter checker for adaptive_scrubber, attached with bind.
// Assumes the same parameters as the checked instance.
module adaptive_scrubber_chk #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [71:0]       mem_wdata,
    input logic [CNT_W-1:0]  corr_count,
    input logic [CNT_W-1:0]  uncorr_count,
    input logic              err_irq
);

    logic [ADDR_W-1:0] last_rd_q;
    logic              rd_seen_q;

    // Remember the address of the latest granted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_q <= '0;
            rd_seen_q <= 1'b0;
        end else if (mem_req && mem_gnt && !mem_we) begin
            last_rd_q <= mem_addr;
            rd_seen_q <= 1'b1;
        end
    end

    // R4: a stalled request keeps all its fields
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R2: a write-back goes to the address just read
    a_r2_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && mem_we |-> rd_seen_q && mem_addr == last_rd_q);

    // R3: the interrupt is sticky
    a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> err_irq);

    // R3: an interrupt implies a counted uncorrectable word
    a_r3_irq_counted: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> uncorr_count != '0);

    // R9: corrected counter only holds or steps up by one
    a_r9_corr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> corr_count == $past(corr_count) || corr_count == $past(corr_count) + CNT_W'(1));

    // R9: uncorrectable counter only holds or steps up by one
    a_r9_uncorr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> uncorr_count == $past(uncorr_count) || uncorr_count == $past(uncorr_count) + CNT_W'(1));

endmodule

bind adaptive_scrubber adaptive_scrubber_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .corr_count(corr_count),
    .uncorr_count(uncorr_count), .err_irq(err_irq)
);

// File: tb/adaptive_scrubber_tb_top.sv
`timescale 1ns/1ps
module adaptive_scrubber_tb_top;

    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int INT_W = 8;
    localparam int CNT_W = 2;

    logic             clk, rst_n, gnt, req, we, irq;
    logic [AW-1:0]    addr, eaddr;
    logic [71:0]      wdata, rdata;
    logic [CNT_W-1:0] ccnt, ucnt;

    adaptive_scrubber #(.DEPTH(DEPTH), .INT_W(INT_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base_interval(8'd64), .cfg_min_interval(8'd8),
        .mem_req(req), .mem_gnt(gnt), .mem_addr(addr), .mem_we(we), .mem_wdata(wdata),
        .mem_rdata(rdata), .corr_count(ccnt), .uncorr_count(ucnt), .err_addr(eaddr), .err_irq(irq)
    );

    typedef struct { int a; logic [71:0] d; } wr_item_t;
    wr_item_t    exp_q[$];
    logic [71:0] mem[DEPTH];
    logic [71:0] orig[DEPTH];
    int checks = 0, fails = 0, last_reads = 0, pass_starts = 0, exp_rd = 0, low_run = 0;
    int gaps[16];
    logic prev_req = 1'b0, stall_pend = 1'b0, stall_we;
    logic [AW-1:0] stall_addr;
    logic [71:0]   stall_wd;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic logic [71:0] encode(input logic [63:0] d);
        logic [71:0] w;
        logic [6:0]  c;
        int di;
        c = '0; di = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[di]) c ^= 7'(p);
                di++;
            end
        end
        w = {1'b0, c, d};
        w[71] = ^w[70:0];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic inj_single(input int a, input int b);
        mem[a][b] = ~mem[a][b];
        exp_q.push_back('{a, orig[a]});
    endtask

    task automatic wait_pass_end(input int n);
        int lows;
        wait (last_reads >= n);
        lows = 0;
        while (lows < 3) begin
            @(negedge clk);
            lows = req ? 0 : lows + 1;
        end
    endtask

    // Arbiter grant pattern with periodic stalls
    initial begin
        int cyc;
        cyc = 0; gnt = 1'b0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            gnt = (cyc % 7 != 3) && (cyc % 11 != 5);
        end
    end

    // Synchronous memory model, one-cycle read latency (R4)
    initial begin
        rdata = '0;
        forever begin
            @(posedge clk);
            if (req && gnt) begin
                if (we) mem[addr] = wdata;
                else    rdata <= mem[addr];
            end
        end
    end

    // Monitor: read order, stall hold, pass gaps, scoreboard of write-backs
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_pend)
                chk("R4 stalled request held", {req, we, addr, wdata[63:0]}, {1'b1, stall_we, stall_addr, stall_wd[63:0]});
            stall_pend = req && !gnt;
            stall_we = we; stall_addr = addr; stall_wd = wdata;
            if (req && !prev_req && !we && addr == 0) begin
                gaps[pass_starts] = low_run;
                pass_starts++;
            end
            low_run = req ? 0 : low_run + 1;
            if (req && gnt && !we) begin
                chk("R5 read address order", 72'(addr), 72'(exp_rd));
                exp_rd = (exp_rd + 1) % DEPTH;
                if (int'(addr) == DEPTH - 1) last_reads++;
            end
            if (req && gnt && we) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1/R3 unexpected write: actual addr %0d data %h expected none", addr, wdata);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    chk("R2 write-back address", 72'(addr), 72'(it.a));
                    chk("R2 write-back data", wdata, it.d);
                end
            end
            prev_req = req;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected run completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            orig[i] = encode({32'(i * 32'h9E37_79B9 + 1), 32'(i * 32'h85EB_CA6B ^ 32'h5A5A_0F0F)});
            mem[i]  = orig[i];
        end
        // Pass 1 errors: two singles, one double
        inj_single(2, 10);
        inj_single(5, 66);
        mem[6][3]  = ~mem[6][3];
        mem[6][40] = ~mem[6][40];
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 reset req", 72'(req), 72'(0));
        chk("R10 reset irq", 72'(irq), 72'(0));
        chk("R10 reset counters", 72'({ccnt, ucnt}), 72'(0));
        @(posedge clk); #1 rst_n = 1'b1;

        wait_pass_end(1);
        chk("R2 corrected count pass 1", 72'(ccnt), 72'(2));
        chk("R3 uncorrectable count pass 1", 72'(ucnt), 72'(1));
        chk("R3 interrupt raised", 72'(irq), 72'(1));
        chk("R3 failing address", 72'(eaddr), 72'(6));
        chk("R2 memory word 2 repaired", mem[2], orig[2]);
        chk("R2 memory word 5 repaired", mem[5], orig[5]);
        chk("R3 double-error word left unwritten", 72'(mem[6] == orig[6]), 72'(0));

        wait_pass_end(2);
        chk("R6 R7 gap before pass 2 (interval 32)", 72'(gaps[1]), 72'(34));
        chk("R1 clean pass changes no corrected count", 72'(ccnt), 72'(2));
        chk("R1 no pending write-backs", 72'(exp_q.size()), 72'(0));

        inj_single(0, 71);
        inj_single(1, 64);
        inj_single(3, 63);
        inj_single(4, 0);
        wait_pass_end(3);
        chk("R8 gap before pass 3 (interval 64)", 72'(gaps[2]), 72'(66));
        chk("R9 corrected counter saturates", 72'(ccnt), 72'(3));
        chk("R3 uncorrectable count pass 3", 72'(ucnt), 72'(3));

        inj_single(7, 20);
        wait_pass_end(4);
        chk("R7 gap before pass 4 (interval 32)", 72'(gaps[3]), 72'(34));
        chk("R9 uncorrectable counter saturates", 72'(ucnt), 72'(3));

        inj_single(3, 70);
        wait_pass_end(5);
        chk("R6 R7 gap after last-word rewrite (interval 16)", 72'(gaps[4]), 72'(16));

        inj_single(1, 33);
        wait_pass_end(6);
        chk("R7 gap before pass 6 (interval 8)", 72'(gaps[5]), 72'(10));

        wait_pass_end(7);
        chk("R7 interval floor at minimum", 72'(gaps[6]), 72'(10));

        wait_pass_end(8);
        chk("R8 gap after clean pass (interval 16)", 72'(gaps[7]), 72'(18));
        chk("R3 interrupt still held", 72'(irq), 72'(1));
        chk("R2 all write-backs seen", 72'(exp_q.size()), 72'(0));
        for (int i = 0; i < DEPTH; i++)
            if (i != 6) chk("R2 final memory content", mem[i], orig[i]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule